// File: doc/BRIEF.md
# Dithered AM Quantizer for a Few-Bit Resistor DAC

This block forms an amplitude-modulated RF sample and reduces it to a handful of bits that can drive a passive resistor DAC. An unsigned 9-bit carrier sample is multiplied by an unsigned 9-bit composite video sample. The video sample already carries its DC offset, so the 18-bit product is the modulated waveform. Uniform pseudo-random noise is then added to that product. Only the top few bits of the sum are kept. The noise spreads the truncation error into a broadband floor instead of discrete spurs.

Two output formats are available, one per resistor network. In ladder mode the four top bits of the dithered sum are driven out in plain binary for an R/2R ladder. In thermometer mode the three top bits are expanded into a seven-line thermometer code for a network of equal resistors. The mode select travels down the pipeline with its sample, so a change of mode takes effect exactly with the sample presented alongside it.

Top module: `am_dither_quantizer`

## Requirements
- R1: The modulated word is the unsigned 18-bit product carrier_i × video_i. If either input is zero, the output three cycles later is zero in both modes.
- R2: The noise source is a 32-bit shift register. After reset it holds 32'h1D2C3B4A. On every clock edge out of reset it shifts left, and the new bit 0 is the XOR of bits 31, 21, 1 and 0. The noise added to a product is the state's low 14 bits in ladder mode and low 15 bits in thermometer mode. The state used is the one present at the edge where that product enters the adder.
- R3: The sum of product and noise saturates at 2^18−1 and never wraps. With both inputs at 511 the output is 4'hF in ladder mode and 7'h7F in thermometer mode.
- R4: In ladder mode (therm_mode_i = 0), dac_o[3:0] equals bits 17:14 of the saturated sum, and dac_o[6:4] is zero.
- R5: In thermometer mode (therm_mode_i = 1), let k be bits 17:15 of the saturated sum. Then dac_o[i] = 1 exactly for i < k, so k = 0 gives 7'h00 and k = 7 gives 7'h7F.
- R6: A sample and its mode presented before clock edge n appear on dac_o after edge n+2, which is three register stages. The samples before and after a mode change are each encoded in their own mode.
- R7: While rst_n is low, dac_o is zero immediately, independent of the clock, and the noise state returns to its seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, released in step with clk |
| carrier_i | input | 9 | Unsigned carrier sample |
| video_i | input | 9 | Unsigned DC-shifted composite video sample |
| therm_mode_i | input | 1 | 0 = 4-bit binary ladder output, 1 = 7-line thermometer output |
| dac_o | output | 7 | Resistor DAC drive bits |

## Verification
A wrong noise state or tap shows at the ports within three cycles of reset. The product's low bits then round differently from the expected sequence, and the top-bit output diverges on the first sample near a code boundary. A wrap instead of saturation makes full-scale inputs collapse to a near-zero code three cycles after they are applied. A lost or misaligned mode bit shows on the sample right after a mode change, either as a non-zero upper nibble in ladder mode or as a binary pattern in place of a thermometer pattern.

// File: rtl/am_dither_pkg.sv
package am_dither_pkg;

  typedef enum logic {
    MODE_LADDER = 1'b0,
    MODE_THERM  = 1'b1
  } dac_mode_e;

  localparam int unsigned RND_W    = 32;
  localparam logic [31:0] RND_SEED = 32'h1D2C_3B4A;

  // maximal-length feedback: x^32 + x^22 + x^2 + x + 1
  function automatic logic [31:0] rnd_advance(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

endpackage

// File: rtl/am_dither_mult.sv
module am_dither_mult
  import am_dither_pkg::*;
#(
  parameter int unsigned CAR_W = 9,
  parameter int unsigned VID_W = 9,
  localparam int unsigned PROD_W = CAR_W + VID_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CAR_W-1:0]  car_i,
  input  logic [VID_W-1:0]  vid_i,
  input  dac_mode_e         mode_i,
  output logic [PROD_W-1:0] prod_q,
  output dac_mode_e         mode_q
);

  logic [PROD_W-1:0] prod_d;
  logic              stage_en;

  always_comb begin
    stage_en = 1'b1;
    prod_d   = PROD_W'(car_i) * PROD_W'(vid_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
      mode_q <= MODE_LADDER;
    end else if (stage_en) begin
      prod_q <= prod_d;
      mode_q <= mode_i;
    end
  end

endmodule

// File: rtl/am_dither_rng.sv
module am_dither_rng
  import am_dither_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  output logic [RND_W-1:0] state_q
);

  logic [RND_W-1:0] state_d;

  always_comb begin
    state_d = rnd_advance(state_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RND_SEED;
    end else begin
      state_q <= state_d;
    end
  end

endmodule

// File: rtl/am_dither_sat_add.sv
module am_dither_sat_add
  import am_dither_pkg::*;
#(
  parameter int unsigned PROD_W   = 18,
  parameter int unsigned LAD_DROP = 14,
  parameter int unsigned THM_DROP = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PROD_W-1:0] prod_i,
  input  dac_mode_e         mode_i,
  input  logic [RND_W-1:0]  rnd_i,
  output logic [PROD_W-1:0] sum_q,
  output dac_mode_e         mode_q
);

  localparam logic [PROD_W:0] LAD_MASK = (PROD_W+1)'((64'd1 << LAD_DROP) - 64'd1);
  localparam logic [PROD_W:0] THM_MASK = (PROD_W+1)'((64'd1 << THM_DROP) - 64'd1);

  logic [PROD_W:0]   noise;
  logic [PROD_W:0]   wide_sum;
  logic [PROD_W-1:0] sum_d;
  logic              stage_en;

  always_comb begin
    stage_en = 1'b1;
    noise    = rnd_i[PROD_W:0] & ((mode_i == MODE_THERM) ? THM_MASK : LAD_MASK);
    wide_sum = {1'b0, prod_i} + noise;
    sum_d    = wide_sum[PROD_W] ? {PROD_W{1'b1}} : wide_sum[PROD_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q  <= '0;
      mode_q <= MODE_LADDER;
    end else if (stage_en) begin
      sum_q  <= sum_d;
      mode_q <= mode_i;
    end
  end

endmodule

// File: rtl/am_dither_encode.sv
module am_dither_encode
  import am_dither_pkg::*;
#(
  parameter int unsigned PROD_W   = 18,
  parameter int unsigned LAD_BITS = 4,
  parameter int unsigned THM_BITS = 3,
  localparam int unsigned OUT_W   = (1 << THM_BITS) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PROD_W-1:0] sum_i,
  input  dac_mode_e         mode_i,
  output logic [OUT_W-1:0]  dac_q
);

  logic [THM_BITS-1:0] level;
  logic [OUT_W-1:0]    therm;
  logic [OUT_W-1:0]    dac_d;
  logic                stage_en;

  assign level = sum_i[PROD_W-1 -: THM_BITS];

  for (genvar i = 0; i < OUT_W; i++) begin : g_therm
    assign therm[i] = (32'(level) > i);
  end

  always_comb begin
    stage_en = 1'b1;
    if (mode_i == MODE_THERM) begin
      dac_d = therm;
    end else begin
      dac_d = OUT_W'(sum_i[PROD_W-1 -: LAD_BITS]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_q <= '0;
    end else if (stage_en) begin
      dac_q <= dac_d;
    end
  end

endmodule

// File: rtl/am_dither_quantizer.sv
module am_dither_quantizer
  import am_dither_pkg::*;
#(
  parameter int unsigned CAR_W    = 9,
  parameter int unsigned VID_W    = 9,
  parameter int unsigned LAD_BITS = 4,
  parameter int unsigned THM_BITS = 3,
  localparam int unsigned PROD_W  = CAR_W + VID_W,
  localparam int unsigned OUT_W   = (1 << THM_BITS) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CAR_W-1:0] carrier_i,
  input  logic [VID_W-1:0] video_i,
  input  logic             therm_mode_i,
  output logic [OUT_W-1:0] dac_o
);

  localparam int unsigned LAD_DROP = PROD_W - LAD_BITS;
  localparam int unsigned THM_DROP = PROD_W - THM_BITS;

  dac_mode_e         mode_in;
  dac_mode_e         mode_s1;
  dac_mode_e         mode_s2;
  logic [PROD_W-1:0] prod_s1;
  logic [PROD_W-1:0] sum_s2;
  logic [RND_W-1:0]  rnd_w;

  assign mode_in = therm_mode_i ? MODE_THERM : MODE_LADDER;

  am_dither_mult #(.CAR_W(CAR_W), .VID_W(VID_W)) u_mult (
    .clk    (clk),
    .rst_n  (rst_n),
    .car_i  (carrier_i),
    .vid_i  (video_i),
    .mode_i (mode_in),
    .prod_q (prod_s1),
    .mode_q (mode_s1)
  );

  am_dither_rng u_rng (
    .clk     (clk),
    .rst_n   (rst_n),
    .state_q (rnd_w)
  );

  am_dither_sat_add #(.PROD_W(PROD_W), .LAD_DROP(LAD_DROP), .THM_DROP(THM_DROP)) u_add (
    .clk    (clk),
    .rst_n  (rst_n),
    .prod_i (prod_s1),
    .mode_i (mode_s1),
    .rnd_i  (rnd_w),
    .sum_q  (sum_s2),
    .mode_q (mode_s2)
  );

  am_dither_encode #(.PROD_W(PROD_W), .LAD_BITS(LAD_BITS), .THM_BITS(THM_BITS)) u_enc (
    .clk    (clk),
    .rst_n  (rst_n),
    .sum_i  (sum_s2),
    .mode_i (mode_s2),
    .dac_q  (dac_o)
  );

endmodule

// File: rtl/am_dither_quantizer_chk.sv
module am_dither_quantizer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [8:0]  carrier_i,
  input logic [8:0]  video_i,
  input logic        therm_mode_i,
  input logic [6:0]  dac_o,
  input logic [31:0] rnd_state
);

  logic [1:0] warm_q;
  logic       warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warm_q <= 2'd0;
    end else if (warm_q != 2'd3) begin
      warm_q <= warm_q + 2'd1;
    end
  end

  assign warm = (warm_q == 2'd3);

  assert_reset_quiet_R7: assert property (@(posedge clk) !rst_n |-> (dac_o == 7'd0));

  assert_rng_alive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rnd_state != 32'd0);

  assert_zero_product_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && ($past(carrier_i, 3) == 9'd0 || $past(video_i, 3) == 9'd0)) |-> (dac_o == 7'd0));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(carrier_i, 3) == 9'h1FF && $past(video_i, 3) == 9'h1FF)
      |-> (dac_o == ($past(therm_mode_i, 3) ? 7'h7F : 7'h0F)));

  assert_ladder_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && !$past(therm_mode_i, 3)) |-> (dac_o[6:4] == 3'd0));

  assert_therm_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(therm_mode_i, 3)) |-> ((dac_o & (dac_o + 7'd1)) == 7'd0));

endmodule

bind am_dither_quantizer am_dither_quantizer_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .carrier_i    (carrier_i),
  .video_i      (video_i),
  .therm_mode_i (therm_mode_i),
  .dac_o        (dac_o),
  .rnd_state    (rnd_w)
);

// File: tb/am_dither_quantizer_tb.sv
module am_dither_quantizer_tb;

  logic       clk;
  logic       rst_n;
  logic [8:0] carrier_i;
  logic [8:0] video_i;
  logic       therm_mode_i;
  logic [6:0] dac_o;

  int unsigned n_chk;
  int unsigned n_bad;
  bit          done;

  am_dither_quantizer u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .carrier_i    (carrier_i),
    .video_i      (video_i),
    .therm_mode_i (therm_mode_i),
    .dac_o        (dac_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // ---- reference model written from R1..R7 ----
  function automatic logic [31:0] ref_step(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  function automatic logic [17:0] ref_sum(input logic [17:0] p, input logic m, input logic [31:0] r);
    logic [18:0] t;
    t = {1'b0, p} + (m ? {4'd0, r[14:0]} : {5'd0, r[13:0]});
    return t[18] ? 18'h3FFFF : t[17:0];
  endfunction

  function automatic logic [6:0] ref_enc(input logic [17:0] s, input logic m);
    logic [6:0] v;
    v = '0;
    if (m) begin
      for (int i = 0; i < 7; i++) v[i] = (int'(s[17:15]) > i);
    end else begin
      v = {3'd0, s[17:14]};
    end
    return v;
  endfunction

  logic [31:0] m_rnd;
  logic [17:0] m_prod, m_sum;
  logic        m_md1, m_md2, m_md3;
  logic [6:0]  m_exp;
  logic [2:0]  m_v;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rnd <= 32'h1D2C_3B4A;
      m_prod <= '0; m_sum <= '0; m_exp <= '0;
      m_md1 <= 1'b0; m_md2 <= 1'b0; m_md3 <= 1'b0;
      m_v <= '0;
    end else begin
      m_prod <= 18'(carrier_i) * 18'(video_i);
      m_md1  <= therm_mode_i;
      m_sum  <= ref_sum(m_prod, m_md1, m_rnd);
      m_md2  <= m_md1;
      m_exp  <= ref_enc(m_sum, m_md2);
      m_md3  <= m_md2;
      m_rnd  <= ref_step(m_rnd);
      m_v    <= {m_v[1:0], 1'b1};
    end
  end

  task automatic check(input logic [6:0] act, input logic [6:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: dac_o=%h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle: compare at the falling edge, then drive the next sample
  task automatic step(input logic m, input logic [8:0] c, input logic [8:0] v);
    @(negedge clk);
    if (m_v[2]) check(dac_o, m_exp, m_md3 ? "R5/R2/R6" : "R4/R2/R6");
    therm_mode_i = m;
    carrier_i    = c;
    video_i      = v;
  endtask

  // {mode, carrier, video}
  localparam logic [18:0] VEC [16] = '{
    {1'b0, 9'd300, 9'd200}, {1'b0, 9'd511, 9'd256}, {1'b1, 9'd128, 9'd128},
    {1'b1, 9'd400, 9'd450}, {1'b0, 9'd17,  9'd480}, {1'b1, 9'd255, 9'd255},
    {1'b0, 9'd256, 9'd256}, {1'b0, 9'd511, 9'd510}, {1'b1, 9'd1,   9'd1  },
    {1'b1, 9'd500, 9'd64 }, {1'b0, 9'd360, 9'd360}, {1'b1, 9'd511, 9'd400},
    {1'b0, 9'd90,  9'd300}, {1'b1, 9'd181, 9'd181}, {1'b0, 9'd450, 9'd490},
    {1'b1, 9'd320, 9'd410}
  };

  initial begin
    n_chk = 0; n_bad = 0; done = 0;
    rst_n = 1'b0; carrier_i = '0; video_i = '0; therm_mode_i = 1'b0;
    // R7: reset state
    repeat (2) @(negedge clk);
    check(dac_o, 7'd0, "R7");
    carrier_i = 9'h1FF; video_i = 9'h1FF;
    @(negedge clk);
    check(dac_o, 7'd0, "R7");
    carrier_i = '0; video_i = '0;
    rst_n = 1'b1;

    // table walk, one sample per cycle, including mode flips (R6)
    for (int i = 0; i < 16; i++) step(VEC[i][18], VEC[i][17:9], VEC[i][8:0]);
    for (int i = 15; i >= 0; i--) step(VEC[i][18], VEC[i][17:9], VEC[i][8:0]);

    // R1: zero product in both modes
    repeat (4) step(1'b0, 9'd0, 9'd400);
    check(dac_o, 7'h00, "R1");
    repeat (4) step(1'b1, 9'd350, 9'd0);
    check(dac_o, 7'h00, "R1");

    // R3: full scale saturates, no wrap
    repeat (4) step(1'b0, 9'h1FF, 9'h1FF);
    check(dac_o, 7'h0F, "R3");
    repeat (4) step(1'b1, 9'h1FF, 9'h1FF);
    check(dac_o, 7'h7F, "R3");

    // R6: latency of exactly three edges after a lone sample
    step(1'b0, 9'd0, 9'd0);
    step(1'b1, 9'h1FF, 9'h1FF);
    step(1'b0, 9'd0, 9'd0);
    step(1'b0, 9'd0, 9'd0);
    check(dac_o, 7'h00, "R6");
    step(1'b0, 9'd0, 9'd0);
    check(dac_o, 7'h7F, "R6");
    step(1'b0, 9'd0, 9'd0);
    check(dac_o, 7'h00, "R6");

    // R7: asynchronous reset mid-stream, then noise restarts from seed (R2)
    repeat (3) step(1'b1, 9'h1FF, 9'h1FF);
    @(negedge clk);
    rst_n = 1'b0;
    #1 check(dac_o, 7'd0, "R7");
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 16; i++) step(VEC[i][18], VEC[i][17:9], VEC[i][8:0]);
    repeat (3) step(1'b0, 9'd0, 9'd0);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete, actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule